// File: doc/BRIEF.md
# Program Fetch Address Router

This block sits between the instruction-fetch unit of an 8052-style core and the two places code can live: an on-chip code memory and an off-chip program bus. While reset is held it samples a boot-source strap. A low strap makes every fetch go to the off-chip bus. A high strap makes fetches go to the on-chip code memory by default.

In on-chip mode the code memory covers addresses 0000H up to a parameterised last address, F7FFH by default. Fetches above that address are not forwarded anywhere. They are answered with a no-operation opcode, so code that runs past the end of the on-chip space never reaches the off-chip bus.

Both memories are synchronous read ports. Each returns its byte in the clock cycle after it is strobed. The router presents the returned byte to the core one cycle after the fetch request, together with a valid strobe. A status output reports which boot source was latched.

Top module: `fetch_addr_router`

## Requirements
- R1: While `rst_n` is low, the router samples `boot_strap_n` on every rising clock edge. After release, `boot_ext` is 1 if the last sampled strap was low (off-chip mode) and 0 if it was high (on-chip mode).
- R2: After reset is released, `boot_ext` and the routing mode stay constant whatever `boot_strap_n` does, until the next reset.
- R3: In off-chip mode, each fetch drives `ext_req` high in the same cycle with `ext_addr` equal to `fetch_addr`, and keeps `int_req` low. This holds for every address, including F800H to FFFFH.
- R4: In on-chip mode, a fetch at or below the last on-chip address (F7FFH) drives `int_req` high in the same cycle with `int_addr` equal to `fetch_addr`, and keeps `ext_req` low.
- R5: In on-chip mode, a fetch above F7FFH strobes neither memory port. It returns the opcode 00H.
- R6: `fetch_valid` is high in the cycle after each cycle in which `fetch_req` is high. In that cycle `fetch_data` carries the byte that the selected port returned for that fetch, or 00H for a fetch answered by R5.
- R7: In a cycle without `fetch_req`, neither `int_req` nor `ext_req` is high, and `fetch_valid` is low in the following cycle.
- R8: While reset is held, `fetch_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| boot_strap_n | input | 1 | Boot-source strap; low selects the off-chip program bus |
| fetch_req | input | 1 | Fetch request from the core |
| fetch_addr | input | 16 | Fetch address |
| fetch_valid | output | 1 | Returned opcode byte is valid |
| fetch_data | output | 8 | Returned opcode byte |
| int_req | output | 1 | Read strobe to the on-chip code memory |
| int_addr | output | 16 | Address to the on-chip code memory |
| int_rdata | input | 8 | Byte from the on-chip code memory, one cycle after its strobe |
| ext_req | output | 1 | Read strobe to the off-chip program bus |
| ext_addr | output | 16 | Address to the off-chip program bus |
| ext_rdata | input | 8 | Byte from the off-chip bus, one cycle after its strobe |
| boot_ext | output | 1 | Latched boot source; 1 means off-chip |

## Verification
The memory strobes and addresses are combinational, so they are due in the same cycle as the fetch request. The bench drives the request on a falling edge and checks the strobes 1 ns later. The returned byte and `fetch_valid` pass through one register, so the bench checks them at the next falling edge, one full cycle after the request. It also confirms that `fetch_valid` falls again in the idle cycle after that. The bench's memory models register their data on the same rising edge as the router, which makes the byte the bench expects in that cycle a known function of the fetch address.

// File: rtl/far_pkg.sv
package far_pkg;
   // Where the byte for a pending fetch comes from
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_INT  = 2'd1,
      SRC_EXT  = 2'd2,
      SRC_NOP  = 2'd3
   } fetch_src_e;
endpackage

// File: rtl/far_boot_latch.sv
module far_boot_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_n,
   output logic ext_mode
);
   // Follows the strap throughout reset, frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) ext_mode <= ~strap_n;
   end

   // R2
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(ext_mode));
endmodule

// File: rtl/far_addr_decode.sv
module far_addr_decode
   import far_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] INT_LAST = 16'hF7FF
) (
   input  logic              ext_mode,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic              int_req,
   output logic              ext_req,
   output logic [ADDR_W-1:0] int_addr,
   output logic [ADDR_W-1:0] ext_addr,
   output fetch_src_e        src
);
   localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

   logic in_hole;

   generate
      if (INT_LAST == ADDR_MAX) begin : gen_full_space
         assign in_hole = 1'b0;
      end else begin : gen_top_hole
         assign in_hole = (addr > INT_LAST);
      end
   endgenerate

   assign int_addr = addr;
   assign ext_addr = addr;

   always_comb begin
      int_req = 1'b0;
      ext_req = 1'b0;
      src     = SRC_NONE;
      if (req) begin
         if (ext_mode) begin
            ext_req = 1'b1;
            src     = SRC_EXT;
         end else if (in_hole) begin
            src     = SRC_NOP;
         end else begin
            int_req = 1'b1;
            src     = SRC_INT;
         end
      end
   end
endmodule

// File: rtl/far_return_stage.sv
module far_return_stage
   import far_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fetch_src_e        src_in,
   input  logic [DATA_W-1:0] int_rdata,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   fetch_src_e src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= SRC_NONE;
      else        src_q <= src_in;
   end

   assign valid = (src_q != SRC_NONE);

   always_comb begin
      unique case (src_q)
         SRC_INT: data = int_rdata;
         SRC_EXT: data = ext_rdata;
         default: data = NOP_CODE;
      endcase
   end

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !valid || rst_n);
endmodule

// File: rtl/fetch_addr_router.sv
module fetch_addr_router
   import far_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] INT_LAST = 16'hF7FF,
   parameter logic [DATA_W-1:0] NOP_CODE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_strap_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_valid,
   output logic [DATA_W-1:0] fetch_data,
   output logic              int_req,
   output logic [ADDR_W-1:0] int_addr,
   input  logic [DATA_W-1:0] int_rdata,
   output logic              ext_req,
   output logic [ADDR_W-1:0] ext_addr,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic              boot_ext
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : gen_bad_addr_w
         $error("fetch_addr_router: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : gen_bad_data_w
         $error("fetch_addr_router: DATA_W must be positive");
      end
   endgenerate

   fetch_src_e src;

   far_boot_latch u_boot (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_n  (boot_strap_n),
      .ext_mode (boot_ext)
   );

   far_addr_decode #(.ADDR_W(ADDR_W), .INT_LAST(INT_LAST)) u_dec (
      .ext_mode (boot_ext),
      .req      (fetch_req),
      .addr     (fetch_addr),
      .int_req  (int_req),
      .ext_req  (ext_req),
      .int_addr (int_addr),
      .ext_addr (ext_addr),
      .src      (src)
   );

   far_return_stage #(.DATA_W(DATA_W), .NOP_CODE(NOP_CODE)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src),
      .int_rdata (int_rdata),
      .ext_rdata (ext_rdata),
      .valid     (fetch_valid),
      .data      (fetch_data)
   );

   // R3
   ext_mode_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_ext && fetch_req) |-> (ext_req && !int_req && ext_addr == fetch_addr));

   // R5
   hole_no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot_ext && fetch_req && fetch_addr > INT_LAST) |-> (!int_req && !ext_req));

   // R5
   hole_nop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!boot_ext && fetch_req && fetch_addr > INT_LAST))
         |-> (fetch_valid && fetch_data == NOP_CODE));

   // R6
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fetch_req)) |-> fetch_valid);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_req |-> (!int_req && !ext_req));

   // R3
   ports_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({int_req, ext_req}));
endmodule

// File: tb/fetch_addr_router_tb_top.sv
module fetch_addr_router_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_strap_n = 1'b1;
   logic        fetch_req = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic        fetch_valid;
   logic [7:0]  fetch_data;
   logic        int_req, ext_req, boot_ext;
   logic [15:0] int_addr, ext_addr;
   logic [7:0]  int_rdata = '0;
   logic [7:0]  ext_rdata = '0;

   int tests_run = 0;
   int tests_failed = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fetch_addr_router dut_i (
      .clk(clk), .rst_n(rst_n), .boot_strap_n(boot_strap_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .fetch_data(fetch_data),
      .int_req(int_req), .int_addr(int_addr), .int_rdata(int_rdata),
      .ext_req(ext_req), .ext_addr(ext_addr), .ext_rdata(ext_rdata),
      .boot_ext(boot_ext)
   );

   function automatic logic [7:0] int_byte(input logic [15:0] a);
      return a[7:0] ^ 8'h5A ^ {a[11:8], a[15:12]};
   endfunction
   function automatic logic [7:0] ext_byte(input logic [15:0] a);
      return a[15:8] ^ a[7:0] ^ 8'hC3;
   endfunction

   // Synchronous memory models: byte appears the cycle after the strobe
   always @(posedge clk) begin
      if (int_req) int_rdata <= int_byte(int_addr);
      if (ext_req) ext_rdata <= ext_byte(ext_addr);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply_reset(input logic strap_n);
      @(negedge clk);
      rst_n = 1'b0;
      fetch_req = 1'b0;
      boot_strap_n = strap_n;
      repeat (3) @(negedge clk);
      check("R8 valid low in reset", {31'd0, fetch_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 latched boot source", {31'd0, boot_ext}, {31'd0, ~strap_n});
   endtask

   // One fetch: strobes checked in the request cycle, data one cycle later
   task automatic do_fetch(input string req, input logic [15:0] a,
                           input logic exp_int, input logic exp_ext,
                           input logic [7:0] exp_data);
      @(negedge clk);
      fetch_req = 1'b1;
      fetch_addr = a;
      #1;
      check({req, " int_req"}, {31'd0, int_req}, {31'd0, exp_int});
      check({req, " ext_req"}, {31'd0, ext_req}, {31'd0, exp_ext});
      if (exp_int) check({req, " int_addr"}, {16'd0, int_addr}, {16'd0, a});
      if (exp_ext) check({req, " ext_addr"}, {16'd0, ext_addr}, {16'd0, a});
      @(negedge clk);
      fetch_req = 1'b0;
      fetch_addr = 16'h1234;
      #1;
      check("R6 valid after request", {31'd0, fetch_valid}, 32'd1);
      check({req, " data"}, {24'd0, fetch_data}, {24'd0, exp_data});
      check("R7 no strobe when idle", {30'd0, int_req, ext_req}, 32'd0);
      @(negedge clk);
      check("R7 valid low after idle", {31'd0, fetch_valid}, 32'd0);
   endtask

   task automatic test_internal_mode();
      apply_reset(1'b1);
      do_fetch("R4 low address", 16'h0000, 1'b1, 1'b0, int_byte(16'h0000));
      do_fetch("R4 mid address", 16'h8A3C, 1'b1, 1'b0, int_byte(16'h8A3C));
      do_fetch("R4 last internal", 16'hF7FF, 1'b1, 1'b0, int_byte(16'hF7FF));
      do_fetch("R5 first hole", 16'hF800, 1'b0, 1'b0, 8'h00);
      do_fetch("R5 top hole", 16'hFFFF, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic test_strap_ignored();
      boot_strap_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 flag holds after strap change", {31'd0, boot_ext}, 32'd0);
      do_fetch("R2 still internal", 16'h0100, 1'b1, 1'b0, int_byte(16'h0100));
      do_fetch("R2 hole still nop", 16'hFA00, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic test_external_mode();
      apply_reset(1'b0);
      do_fetch("R3 low address", 16'h0040, 1'b0, 1'b1, ext_byte(16'h0040));
      do_fetch("R3 last internal", 16'hF7FF, 1'b0, 1'b1, ext_byte(16'hF7FF));
      do_fetch("R3 hole address", 16'hF9A5, 1'b0, 1'b1, ext_byte(16'hF9A5));
      boot_strap_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R2 ext flag holds", {31'd0, boot_ext}, 32'd1);
      do_fetch("R2 still external", 16'h2222, 1'b0, 1'b1, ext_byte(16'h2222));
   endtask

   task automatic test_back_to_internal();
      apply_reset(1'b1);
      do_fetch("R1 internal after re-reset", 16'h7777, 1'b1, 1'b0, int_byte(16'h7777));
   endtask

   initial begin
      test_internal_mode();
      test_strap_ignored();
      test_external_mode();
      test_back_to_internal();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end
endmodule